// File: doc/BRIEF.md
# HMAC Key Register File

This block is the key store that sits beside a hash core able to run keyed-hash (HMAC) jobs. Host software loads up to sixteen 64-bit key words through a plain indexed write port and can read them back through an indexed read port. A 3-bit mode input tells the store which hash algorithm is in use. The mode sets two things: how many key words the algorithm consumes, and whether host data is byte-reversed on its way in and out. The little-endian algorithm (MD5) uses byte-reversed data, and the SHA family uses data as it stands.

When the hash core starts the inner or outer pass of an HMAC, it raises a one-cycle request that selects the pass. The store then streams the key, already XORed with the matching pad byte, one 64-bit word per accepted cycle and in index order. The stream length is 8 words for algorithms with a 64-byte block and 16 words for algorithms with a 128-byte block. A one-cycle done pulse follows the last word. The hash rounds and message buffering live elsewhere.

Top module: `hmac_keyfile`

## Requirements
- R1: A synchronous reset, sampled on the rising clock edge while `rst` is high, clears all sixteen key words, so every host read returns zero in any mode afterwards.
- R2: In any mode other than code 0, a host read of index i returns exactly the 64-bit value last written to index i in a non-zero mode, for all sixteen indices.
- R3: In mode code 0 (MD5), host data is byte-reversed on writes and on reads (bits [7:0] trade places with bits [63:56], and so on). A value written and read in MD5 mode therefore comes back unchanged, and a value written in a SHA mode reads back byte-reversed in MD5 mode.
- R4: Mode codes are 0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256, 4 SHA-384 and 5 SHA-512, and codes 6 and 7 act as SHA-256. Codes 4 and 5 stream 16 words (indices 0 to 15). All other codes stream 8 words (indices 0 to 7), so the contents of words 8 to 15 never reach the core in those modes.
- R5: Each streamed word is the stored key word XOR 0x3636363636363636 when `pad_sel`=0 (inner pass), or XOR 0x5C5C5C5C5C5C5C5C when `pad_sel`=1 (outer pass). The stored word of a value written in MD5 mode is the byte-reversed host value.
- R6: A `pad_req` seen while idle makes `pad_valid` high in the next cycle with `pad_idx`=0. The index advances by one on each cycle where `pad_valid` and `pad_ready` are both high, and it holds while `pad_ready` is low.
- R7: `pad_done` is high for exactly one cycle, the cycle after the handshake on the last word. `pad_valid` is low in that cycle and stays low until the next request.
- R8: A `pad_req` that arrives while a stream is in progress is ignored. The pass selection and the stream length are taken from the inputs at the accepted request, so later changes to `pad_sel` or `mode` do not alter the stream in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Hash algorithm code |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | 4 | Host write index |
| wr_data | input | 64 | Host write data |
| rd_idx | input | 4 | Host read index |
| rd_data | output | 64 | Host read data (combinational) |
| pad_req | input | 1 | Start a padded key stream |
| pad_sel | input | 1 | 0 inner pad, 1 outer pad |
| pad_ready | input | 1 | Core accepts the current word |
| pad_valid | output | 1 | Streamed word is valid |
| pad_idx | output | 4 | Index of the streamed word |
| pad_data | output | 64 | Padded key word |
| pad_done | output | 1 | One-cycle pulse after the last word |

## Verification
A wrong stored word shows at the read port in the same cycle it is addressed. It also shows in the padded stream at the beat for its index, with the pad byte XORed on top. A wrong sequencer state shows within one cycle as a missing or extra valid beat, a skipped or repeated index, or a done pulse that comes early, comes late or lasts too long. A wrong latched mode or pass shows as a stream of the wrong length or the wrong pad constant. The sweeps cover every index in both byte orders, both passes, and both stream lengths under steady and stalling ready patterns. As a result, each of these faults reaches a compared port value within a few cycles.

// File: rtl/hkf_pkg.sv
package hkf_pkg;
  localparam int KEY_W     = 64;
  localparam int KEY_BYTES = KEY_W / 8;

  localparam logic [2:0] MODE_MD5    = 3'd0;
  localparam logic [2:0] MODE_SHA384 = 3'd4;
  localparam logic [2:0] MODE_SHA512 = 3'd5;

  localparam logic [7:0] IPAD_BYTE = 8'h36;
  localparam logic [7:0] OPAD_BYTE = 8'h5C;

  function automatic logic is_little(input logic [2:0] m);
    return m == MODE_MD5;
  endfunction

  function automatic logic is_wide(input logic [2:0] m);
    return (m == MODE_SHA384) || (m == MODE_SHA512);
  endfunction

  function automatic logic [KEY_W-1:0] byte_rev(input logic [KEY_W-1:0] w);
    return {<<8{w}};
  endfunction

  function automatic logic [KEY_W-1:0] pad_word(input logic [KEY_W-1:0] w,
                                                input logic outer);
    return w ^ {KEY_BYTES{outer ? OPAD_BYTE : IPAD_BYTE}};
  endfunction
endpackage

// File: rtl/hkf_store.sv
module hkf_store #(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    little,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [hkf_pkg::KEY_W-1:0] wr_data,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [hkf_pkg::KEY_W-1:0] rd_data,
  input  logic [IDX_W-1:0]        core_idx,
  output logic [hkf_pkg::KEY_W-1:0] core_key
);
  import hkf_pkg::*;

  logic [KEY_W-1:0] regs [NUM_REGS];
  logic [KEY_W-1:0] wr_word;
  logic [KEY_W-1:0] rd_word;

  assign wr_word = little ? byte_rev(wr_data) : wr_data;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst)      regs[i] <= '0;
      else if (hit) regs[i] <= wr_word;
    end
  end

  assign rd_word  = regs[rd_idx];
  assign rd_data  = little ? byte_rev(rd_word) : rd_word;
  assign core_key = regs[core_idx];

  // R1: a reset cycle leaves the addressed word at zero on the next cycle
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> (core_key == '0) || wr_en);
endmodule

// File: rtl/hkf_pad_seq.sv
module hkf_pad_seq #(
  parameter int NUM_REGS    = 16,
  parameter int NARROW_REGS = 8,
  parameter int IDX_W       = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             sel_in,
  input  logic             wide,
  input  logic             ready,
  output logic             valid,
  output logic [IDX_W-1:0] idx,
  output logic             sel,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(NUM_REGS - 1);
  localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(NARROW_REGS - 1);

  logic             busy;
  logic [IDX_W-1:0] last_idx;
  logic             start_ev;
  logic             beat_ev;
  logic             final_ev;

  assign start_ev = req && !busy;
  assign beat_ev  = busy && ready;
  assign final_ev = beat_ev && (idx == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      idx      <= '0;
      last_idx <= '0;
      sel      <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= final_ev;
      if (start_ev) begin
        busy     <= 1'b1;
        idx      <= '0;
        sel      <= sel_in;
        last_idx <= wide ? LAST_WIDE : LAST_NARROW;
      end else if (final_ev) begin
        busy <= 1'b0;
      end else if (beat_ev) begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign valid = busy;

  // R6: an accepted request starts at index 0 on the next cycle
  p_start_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> valid && (idx == '0));
  // R6: a stalled beat keeps its index
  p_stall_holds_r6: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid && $stable(idx));
  // R8: a request during a stream leaves the latched pass alone
  p_busy_req_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    busy && req && !final_ev |=> valid && $stable(sel) && $stable(last_idx));
endmodule

// File: rtl/hmac_keyfile.sv
module hmac_keyfile #(
  parameter int NUM_REGS    = 16,
  parameter int NARROW_REGS = 8,
  localparam int IDX_W      = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [63:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_data,
  input  logic             pad_req,
  input  logic             pad_sel,
  input  logic             pad_ready,
  output logic             pad_valid,
  output logic [IDX_W-1:0] pad_idx,
  output logic [63:0]      pad_data,
  output logic             pad_done
);
  import hkf_pkg::*;

  logic             little_en;
  logic             wide_en;
  logic             seq_sel;
  logic [KEY_W-1:0] core_key;

  assign little_en = is_little(mode);
  assign wide_en   = is_wide(mode);

  hkf_store #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .little   (little_en),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .core_idx (pad_idx),
    .core_key (core_key)
  );

  hkf_pad_seq #(.NUM_REGS(NUM_REGS), .NARROW_REGS(NARROW_REGS), .IDX_W(IDX_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .req    (pad_req),
    .sel_in (pad_sel),
    .wide   (wide_en),
    .ready  (pad_ready),
    .valid  (pad_valid),
    .idx    (pad_idx),
    .sel    (seq_sel),
    .done   (pad_done)
  );

  assign pad_data = pad_word(core_key, seq_sel);

  // R2 / R3: write then read of the same index in the same mode returns the host value
  p_roundtrip_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_idx != $past(wr_idx)) || (mode != $past(mode)) || (rd_data == $past(wr_data)));
  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    pad_done |=> !pad_done);
  // R7: no valid word alongside done
  p_done_no_valid_r7: assert property (@(posedge clk) disable iff (rst)
    pad_done |-> !pad_valid);
  // R6: an accepted beat either advances the index or ends the stream
  p_advance_r6: assert property (@(posedge clk) disable iff (rst)
    pad_valid && pad_ready |=> pad_done || (pad_idx == $past(pad_idx) + 1'b1));
endmodule

// File: tb/tb_hmac_keyfile.sv
module tb_hmac_keyfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  mode;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [63:0] wr_data;
  logic [3:0]  rd_idx;
  logic [63:0] rd_data;
  logic        pad_req, pad_sel, pad_ready;
  logic        pad_valid;
  logic [3:0]  pad_idx;
  logic [63:0] pad_data;
  logic        pad_done;

  int checks = 0;
  int fails  = 0;
  logic [63:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  hmac_keyfile dut (.*);

  function automatic logic [63:0] rev64(input logic [63:0] w);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = w[56 - 8*k +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input int i, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(i); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[i] = (mode == 3'd0) ? rev64(d) : d;
  endtask

  task automatic host_read(input string req, input int i);
    rd_idx = 4'(i);
    #1;
    check(req, rd_data, (mode == 3'd0) ? rev64(model[i]) : model[i]);
  endtask

  // stall: 0 always ready, 1 ready drops every third cycle
  // poke: issue an extra request with the other pass mid stream and change mode
  task automatic run_pad(input logic sel, input int stall, input bit poke);
    int exp_n, beats, cyc;
    bit got_done;
    logic [63:0] padc;
    exp_n = (mode == 3'd4 || mode == 3'd5) ? 16 : 8;
    padc  = sel ? 64'h5C5C5C5C5C5C5C5C : 64'h3636363636363636;
    @(negedge clk);
    pad_req = 1'b1; pad_sel = sel; pad_ready = 1'b0;
    @(negedge clk);
    pad_req = 1'b0;
    check("R6 valid after request", {63'd0, pad_valid}, 64'd1);
    beats = 0; cyc = 0; got_done = 0;
    while (!got_done && cyc < 200) begin
      pad_ready = (stall == 0) ? 1'b1 : ((cyc % 3) != 1);
      if (poke && cyc == 3) begin
        pad_req = 1'b1; pad_sel = ~sel; mode = (exp_n == 8) ? 3'd5 : 3'd3;
      end else begin
        pad_req = 1'b0;
      end
      if (pad_done) begin
        got_done = 1;
        check("R4 stream length", 64'(beats), 64'(exp_n));
        check("R7 no valid with done", {63'd0, pad_valid}, 64'd0);
      end else begin
        check("R6 valid during stream", {63'd0, pad_valid}, 64'd1);
        check("R6 index order", 64'(pad_idx), 64'(beats));
        check("R5 padded word", pad_data, model[beats % 16] ^ padc);
        if (pad_ready) beats++;
      end
      @(negedge clk);
      cyc++;
    end
    pad_req = 1'b0; pad_ready = 1'b0;
    check("R7 done seen", {63'd0, got_done}, 64'd1);
    check("R7 done one cycle", {63'd0, pad_done}, 64'd0);
    check("R7 valid stays low", {63'd0, pad_valid}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; mode = 3'd3; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd_idx = '0; pad_req = 1'b0; pad_sel = 1'b0; pad_ready = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    // preload junk that reset must clear
    @(negedge clk); rst = 1'b0;
    wr_en = 1'b1; wr_idx = 4'd5; wr_data = 64'hDEADBEEFCAFEF00D;
    @(negedge clk); wr_en = 1'b0; rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 16; i++) host_read("R1 reset clears", i);
    mode = 3'd0;
    for (int i = 0; i < 16; i++) host_read("R1 reset clears md5", i);

    // R2: SHA-mode write and read back of every index
    mode = 3'd1;
    for (int i = 0; i < 16; i++)
      host_write(i, {8'(i), 8'h11 * 8'(i), 16'hA5C3 ^ 16'(i * 977), 32'h01234567 + 32'(i * 32'h1F1F)});
    for (int m = 1; m < 8; m++) begin
      mode = 3'(m);
      for (int i = 0; i < 16; i++) host_read("R2 sha readback", i);
    end

    // R3: SHA-written words read byte-reversed in MD5 mode
    mode = 3'd0;
    for (int i = 0; i < 16; i++) host_read("R3 md5 view reversed", i);

    // R4/R5/R6/R7: streams in several modes, both passes, both ready patterns
    for (int m = 0; m < 8; m++) begin
      mode = 3'(m);
      run_pad(1'b0, m % 2, 1'b0);
      mode = 3'(m);
      run_pad(1'b1, (m + 1) % 2, 1'b0);
    end

    // R3: MD5-mode writes are stored reversed and stream reversed
    mode = 3'd0;
    for (int i = 0; i < 8; i++) host_write(i, 64'h0102030405060708 + 64'(i) * 64'h1010101010101010);
    for (int i = 0; i < 16; i++) host_read("R3 md5 roundtrip", i);
    mode = 3'd3;
    for (int i = 0; i < 8; i++) host_read("R3 md5 write seen in sha order", i);
    mode = 3'd0;
    run_pad(1'b1, 1, 1'b0);

    // R4: words 8..15 rewritten, narrow mode stream unaffected
    mode = 3'd2;
    for (int i = 8; i < 16; i++) host_write(i, 64'hFFFF0000FFFF0000 ^ 64'(i));
    run_pad(1'b0, 0, 1'b0);
    mode = 3'd4;
    run_pad(1'b0, 1, 1'b0);

    // R8: request and mode change during a stream are ignored
    mode = 3'd3;
    run_pad(1'b0, 0, 1'b1);
    mode = 3'd5;
    run_pad(1'b1, 1, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule